// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that walks a linked list of four-word descriptors kept in system memory. Software loads the address of the first descriptor and sets the run bit in the channel's control/status register. The channel reads each descriptor, copies the requested number of bytes from the source address to the target address one 32-bit word per beat, and then follows the next pointer. It stops at a descriptor whose next pointer carries the stop flag. A chain whose last pointer leads back to an earlier descriptor never ends; software stops it by clearing run.

Each descriptor supplies its own command word. The command word sets address increment for the source and the target, pacing by a peripheral request line with a burst size, byte swapping, start and end interrupts, and a 13-bit byte count. A register-only mode skips the memory fetch and runs one transfer from the software-loaded source, target and command registers. The channel reports start, end and bus-error events in sticky bits that software clears by writing ones. Any pending event drives a level interrupt output.

Top module: `dchan_top`

## Requirements
- R1: After reset the status word (register index 0) reads 0x00000008, meaning stopped with nothing pending. Register indices 1 to 4 read zero and irq is low.
- R2: A descriptor at address D is read as four words from D with its low four bits cleared, in this order: next pointer, source, target, command. The channel then moves ceil(count/4) words, where count is command bits 12:0. Each word is read at the source and written to the target. After each word the source advances by 4 if command bit 31 is set, and the target advances by 4 if command bit 30 is set; otherwise each stays fixed. A memory request holds its address and direction until it is acknowledged.
- R3: If bit 0 of the next-pointer word is clear, the channel fetches the next descriptor from next-pointer bits 31:4 followed by four zero bits. Register index 1 then reads that address. If bit 0 is set, the chain ends after the current descriptor.
- R4: Status bit 1 is set when a descriptor with command bit 22 is loaded. Status bit 2 is set when a descriptor with command bit 21 finishes.
- R5: When command bit 29 or bit 28 is set, each burst waits for dreq to be high. Command bits 17:16 give the burst size: 0 = 4, 1 = 8, 2 = 16, 3 = 32 bytes. Status bit 8 reads 1 while the channel waits for dreq, and no word moves while dreq is low.
- R6: With command bit 18 set, each word is written with its byte order reversed.
- R7: When a chain ends, status bit 31 (run) clears by itself and status bit 3 (stopped) reads 1.
- R8: When software clears run, the channel halts at the next word boundary and status bit 3 reads 1.
- R9: Status bits 2:0 are write-one-to-clear. Bits 31, 30 and 29 read back the values last written. A new event in the same cycle as a clear wins over the clear.
- R10: A memory response with mem_err sets status bit 0, clears run, and leaves the channel with no further memory access.
- R11: With status bit 30 set when run is set, the channel fetches nothing. It performs one transfer from register indices 2 (source), 3 (target) and 4 (command), then stops.
- R12: A chain that points back to an earlier descriptor keeps repeating and sets status bit 2 again on every pass through a descriptor with command bit 21 set.
- R13: Register indices 2, 3 and 4 read the current source, target and command at any time, including mid-transfer. Writes to indices 1 to 4 are ignored while the channel is not stopped.
- R14: irq is high exactly when any of status bits 2:0 is set, or when bits 29 and 3 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 status, 1 descriptor address, 2 source, 3 target, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dreq | input | 1 | Peripheral request for paced transfers |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid |
| mem_err | input | 1 | Access failed; valid with mem_ack |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Channel interrupt, level |

## Verification
A wrong sequencer state shows up at the memory port within a cycle or two. It appears as a write to an address the scoreboard does not expect, a write with swapped or unswapped data, or a word that moves while dreq is low. A lost word count or a bad next-pointer decode appears as too many or too few target writes, or as a run bit that never clears, and the bench catches this when the chain should have finished. Corrupted status bits appear on the next register read and on irq, which are checked after each end, error, clear and halt.

// File: rtl/dchan_pkg.sv
// Package: shared constants, sequencer state type and helper functions for
// the descriptor-chained DMA channel. Assumes 32-bit words and byte addresses.
package dchan_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 13;
    localparam int BEAT_BYTES = 4;
    localparam int BURST_W    = 6;
    localparam int IDX_W      = 3;

    // command word bit positions
    localparam int C_SRC_INC  = 31;
    localparam int C_TGT_INC  = 30;
    localparam int C_PACE_SRC = 29;
    localparam int C_PACE_TGT = 28;
    localparam int C_START_IE = 22;
    localparam int C_END_IE   = 21;
    localparam int C_SWAP     = 18;
    localparam int C_BURST_LO = 16;

    // status word bit positions
    localparam int S_RUN     = 31;
    localparam int S_NOFETCH = 30;
    localparam int S_STOP_IE = 29;
    localparam int S_REQWAIT = 8;
    localparam int S_STOPPED = 3;
    localparam int S_END     = 2;
    localparam int S_START   = 1;
    localparam int S_BUSERR  = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_LOAD, ST_CHK, ST_WAIT, ST_RD, ST_WR, ST_DEND
    } mv_state_t;

    // bytes in one paced burst for a 2-bit burst code
    function automatic logic [BURST_W-1:0] burst_bytes(input logic [1:0] code);
        case (code)
            2'd1:    burst_bytes = BURST_W'(8);
            2'd2:    burst_bytes = BURST_W'(16);
            2'd3:    burst_bytes = BURST_W'(32);
            default: burst_bytes = BURST_W'(BEAT_BYTES);
        endcase
    endfunction

    // reverse the byte order of a word
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        for (int b = 0; b < WORD_W/8; b++)
            swap_bytes[8*b +: 8] = w[WORD_W-8-8*b +: 8];
    endfunction
endpackage

// File: rtl/dchan_csr.sv
// Control/status register of the channel. Holds run, register-only mode and
// stop-interrupt enable as plain bits, and start/end/bus-error as sticky
// write-one-to-clear flags. Assumes events from the mover are one-cycle pulses;
// an event wins over a same-cycle clear, and finish/error win over a run write.
module dchan_csr
    import dchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              idle_i,
    input  logic              waitreq_i,
    input  logic              start_evt_i,
    input  logic              end_evt_i,
    input  logic              fin_i,
    input  logic              err_i,
    output logic              run_o,
    output logic              nofetch_o,
    output logic [WORD_W-1:0] csr_o,
    output logic              irq_o
);
    logic run_q, nofetch_q, stopie_q, end_q, start_q, berr_q;

    // control bits and sticky event flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            nofetch_q <= 1'b0;
            stopie_q  <= 1'b0;
            end_q     <= 1'b0;
            start_q   <= 1'b0;
            berr_q    <= 1'b0;
        end else begin
            if (wr_i) begin
                run_q     <= wdata_i[S_RUN];
                nofetch_q <= wdata_i[S_NOFETCH];
                stopie_q  <= wdata_i[S_STOP_IE];
                if (wdata_i[S_END])    end_q   <= 1'b0;
                if (wdata_i[S_START])  start_q <= 1'b0;
                if (wdata_i[S_BUSERR]) berr_q  <= 1'b0;
            end
            if (fin_i || err_i) run_q   <= 1'b0;
            if (end_evt_i)      end_q   <= 1'b1;
            if (start_evt_i)    start_q <= 1'b1;
            if (err_i)          berr_q  <= 1'b1;
        end
    end

    // assemble the readable status word
    always_comb begin
        csr_o            = '0;
        csr_o[S_RUN]     = run_q;
        csr_o[S_NOFETCH] = nofetch_q;
        csr_o[S_STOP_IE] = stopie_q;
        csr_o[S_REQWAIT] = waitreq_i;
        csr_o[S_STOPPED] = idle_i;
        csr_o[S_END]     = end_q;
        csr_o[S_START]   = start_q;
        csr_o[S_BUSERR]  = berr_q;
    end

    assign run_o     = run_q;
    assign nofetch_o = nofetch_q;
    assign irq_o     = end_q | start_q | berr_q | (stopie_q & idle_i);

    a_r7_run_cleared_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> !run_q);
    a_r10_error_latched: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (berr_q && !run_q));
    a_r9_end_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[S_END] && !end_evt_i) |=> !end_q);
endmodule

// File: rtl/dchan_mover.sv
// Sequencer and data path of the channel. It fetches four-word descriptors,
// moves one word per beat from source to target, paces bursts on a request
// input and follows next pointers. It also holds the software-visible
// descriptor, source, target and command registers, which accept writes only
// while idle. Assumes a memory port that answers with mem_ack_i (read data
// valid in the same cycle) and keeps each request stable until acknowledged.
module dchan_mover
    import dchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              nofetch_i,
    input  logic              sw_wr_i,
    input  logic [IDX_W-1:0]  sw_idx_i,
    input  logic [WORD_W-1:0] sw_data_i,
    input  logic              dreq_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] nd_o,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] tgt_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              idle_o,
    output logic              waitreq_o,
    output logic              start_evt_o,
    output logic              end_evt_o,
    output logic              fin_o,
    output logic              err_o
);
    localparam int WIDX_W = 2;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(BEAT_BYTES);

    mv_state_t          st;
    logic [WORD_W-1:0]  nd_q, nxt_q, src_q, tgt_q, cmd_q, data_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [BURST_W-1:0] blft_q;
    logic [WIDX_W-1:0]  widx_q;
    logic               nofetch_q;
    logic               paced, in_mem_state, chain_last;

    assign paced        = cmd_q[C_PACE_SRC] | cmd_q[C_PACE_TGT];
    assign in_mem_state = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR);
    assign chain_last   = nofetch_q | nxt_q[0];

    // sequencer state, descriptor registers and beat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            nd_q      <= '0;
            nxt_q     <= '0;
            src_q     <= '0;
            tgt_q     <= '0;
            cmd_q     <= '0;
            data_q    <= '0;
            cnt_q     <= '0;
            blft_q    <= '0;
            widx_q    <= '0;
            nofetch_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (sw_wr_i) begin
                        case (sw_idx_i)
                            IDX_W'(1): nd_q  <= sw_data_i;
                            IDX_W'(2): src_q <= sw_data_i;
                            IDX_W'(3): tgt_q <= sw_data_i;
                            IDX_W'(4): cmd_q <= sw_data_i;
                            default: ;
                        endcase
                    end
                    if (run_i) begin
                        nofetch_q <= nofetch_i;
                        widx_q    <= '0;
                        st        <= nofetch_i ? ST_LOAD : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        if (mem_err_i) begin
                            st <= ST_IDLE;
                        end else begin
                            case (widx_q)
                                2'd0: nxt_q <= mem_rdata_i;
                                2'd1: src_q <= mem_rdata_i;
                                2'd2: tgt_q <= mem_rdata_i;
                                default: cmd_q <= mem_rdata_i;
                            endcase
                            widx_q <= widx_q + 1'b1;
                            if (widx_q == 2'd3) st <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    cnt_q  <= cmd_q[LEN_W-1:0];
                    blft_q <= '0;
                    st     <= ST_CHK;
                end
                ST_CHK: begin
                    if (!run_i)                     st <= ST_IDLE;
                    else if (cnt_q == '0)           st <= ST_DEND;
                    else if (paced && blft_q == '0) st <= ST_WAIT;
                    else                            st <= ST_RD;
                end
                ST_WAIT: begin
                    if (!run_i) begin
                        st <= ST_IDLE;
                    end else if (dreq_i) begin
                        blft_q <= burst_bytes(cmd_q[C_BURST_LO +: 2]);
                        st     <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack_i) begin
                        if (mem_err_i) begin
                            st <= ST_IDLE;
                        end else begin
                            data_q <= cmd_q[C_SWAP] ? swap_bytes(mem_rdata_i) : mem_rdata_i;
                            st     <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ack_i) begin
                        if (mem_err_i) begin
                            st <= ST_IDLE;
                        end else begin
                            if (cmd_q[C_SRC_INC]) src_q <= src_q + STEP;
                            if (cmd_q[C_TGT_INC]) tgt_q <= tgt_q + STEP;
                            cnt_q  <= (cnt_q > LEN_W'(BEAT_BYTES)) ? cnt_q - LEN_W'(BEAT_BYTES) : '0;
                            blft_q <= (blft_q > BURST_W'(BEAT_BYTES)) ? blft_q - BURST_W'(BEAT_BYTES) : '0;
                            st     <= ST_CHK;
                        end
                    end
                end
                ST_DEND: begin
                    if (!run_i || chain_last) begin
                        st <= ST_IDLE;
                    end else begin
                        nd_q   <= {nxt_q[WORD_W-1:4], 4'b0000};
                        widx_q <= '0;
                        st     <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory request for the current state
    always_comb begin
        mem_req_o   = in_mem_state;
        mem_we_o    = (st == ST_WR);
        mem_wdata_o = data_q;
        case (st)
            ST_FETCH: mem_addr_o = {nd_q[WORD_W-1:4], 4'b0000} + WORD_W'({widx_q, 2'b00});
            ST_WR:    mem_addr_o = tgt_q;
            default:  mem_addr_o = src_q;
        endcase
    end

    // event pulses towards the status register
    always_comb begin
        err_o       = in_mem_state && mem_ack_i && mem_err_i;
        start_evt_o = (st == ST_LOAD) && cmd_q[C_START_IE];
        end_evt_o   = (st == ST_DEND) && run_i && cmd_q[C_END_IE];
        fin_o       = (st == ST_DEND) && run_i && chain_last;
    end

    assign idle_o    = (st == ST_IDLE);
    assign waitreq_o = (st == ST_WAIT);
    assign nd_o      = nd_q;
    assign src_o     = src_q;
    assign tgt_o     = tgt_q;
    assign cmd_o     = cmd_q;

    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
    a_r5_no_read_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !dreq_i) |=> (st != ST_RD));
    a_r10_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !mem_req_o);
    a_r7_idle_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> idle_o);
endmodule

// File: rtl/dchan_top.sv
// Top of the descriptor-chained DMA channel: joins the status register and
// the mover, and multiplexes the register read port. Register index 0 is the
// status word; indices 1..4 are descriptor address, source, target, command.
module dchan_top
    import dchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              irq
);
    logic              run, nofetch, idle, waitreq, start_evt, end_evt, fin, err;
    logic [WORD_W-1:0] csr_word, nd, src, tgt, cmd;

    dchan_csr i_csr (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr && reg_addr == '0), .wdata_i(reg_wdata),
        .idle_i(idle), .waitreq_i(waitreq),
        .start_evt_i(start_evt), .end_evt_i(end_evt), .fin_i(fin), .err_i(err),
        .run_o(run), .nofetch_o(nofetch), .csr_o(csr_word), .irq_o(irq)
    );

    dchan_mover i_mover (
        .clk(clk), .rst_n(rst_n), .run_i(run), .nofetch_i(nofetch),
        .sw_wr_i(reg_wr), .sw_idx_i(reg_addr), .sw_data_i(reg_wdata), .dreq_i(dreq),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
        .nd_o(nd), .src_o(src), .tgt_o(tgt), .cmd_o(cmd),
        .idle_o(idle), .waitreq_o(waitreq), .start_evt_o(start_evt), .end_evt_o(end_evt),
        .fin_o(fin), .err_o(err)
    );

    // register read multiplexer
    always_comb begin
        case (reg_addr)
            IDX_W'(0): reg_rdata = csr_word;
            IDX_W'(1): reg_rdata = nd;
            IDX_W'(2): reg_rdata = src;
            IDX_W'(3): reg_rdata = tgt;
            IDX_W'(4): reg_rdata = cmd;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_dchan_top.sv
// Scoreboard bench: tasks push expected target writes into a queue, a monitor
// pops and compares each write the channel makes. Memory answers every other cycle.
module test_dchan_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        mem_req, mem_we, mem_ack, mem_err, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:1023];
    logic        ack_en;
    int          n_chk = 0, n_fail = 0, wr_count = 0;
    bit          sb_on = 1'b1;

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t sb_q[$];

    always #10 clk = ~clk;

    dchan_top i_dchan_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: answers on alternate cycles, errors above 0x80000000
    always @(posedge clk) ack_en <= rst_n ? !ack_en : 1'b0;
    assign mem_ack   = mem_req & ack_en;
    assign mem_err   = mem_ack & mem_addr[31];
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk)
        if (mem_req && mem_we && mem_ack && !mem_err) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare each target write with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack) begin
            wr_count++;
            if (sb_on) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected write", mem_addr, 32'h0);
                end else begin
                    wr_t e;
                    e = sb_q.pop_front();
                    chk(mem_addr == e.a, "R2 write address", mem_addr, e.a);
                    chk(mem_wdata == e.d, "R2/R6 write data", mem_wdata, e.d);
                end
            end
        end
    end

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
        wr_t e;
        e.a = a; e.d = d;
        sb_q.push_back(e);
    endtask

    task automatic wreg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] idx, output logic [31:0] d);
        reg_addr = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int base, input logic [31:0] nx, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] c);
        mem[base/4]     = nx;
        mem[base/4 + 1] = s;
        mem[base/4 + 2] = t;
        mem[base/4 + 3] = c;
    endtask

    task automatic wait_stop(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            @(negedge clk);
            rreg(3'd0, v);
            n++;
        end while (!(v[3] && !v[31]) && n < 2000);
        chk(n < 2000, req, v, 32'h8);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wc0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[32'h400/4] = 32'h11111111;
        mem[32'h404/4] = 32'h22222222;
        mem[32'h500/4] = 32'hA0A1A2A3;
        mem[32'h504/4] = 32'hB0B1B2B3;
        mem[32'h510/4] = 32'h01020304;
        mem[32'h800/4] = 32'hCAFE0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(3'd0, v); chk(v == 32'h8, "R1 status", v, 32'h8);
        for (int k = 1; k < 5; k++) begin
            rreg(k[2:0], v); chk(v == 32'h0, "R1 register", v, 32'h0);
        end
        chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

        // R2 R7 single descriptor, count 6 rounds up to two words
        put_desc(32'h100, 32'h1, 32'h400, 32'h600, 32'hC020_0006);
        expect_wr(32'h600, 32'h11111111);
        expect_wr(32'h604, 32'h22222222);
        wreg(3'd1, 32'h100);
        wreg(3'd0, 32'h8000_0000);
        wait_stop("R7 chain end");
        rreg(3'd0, v); chk(v == 32'hC, "R7 R4 status after end", v, 32'hC);
        chk(sb_q.size() == 0, "R2 all words moved", sb_q.size(), 0);
        chk(irq == 1'b1, "R14 irq on end", {31'b0, irq}, 32'h1);
        wreg(3'd0, 32'h4);
        rreg(3'd0, v); chk(v == 32'h8, "R9 end cleared", v, 32'h8);
        chk(irq == 1'b0, "R14 irq low", {31'b0, irq}, 32'h0);

        // R3 R4 R6 two-descriptor chain, fixed target, start irq, byte swap
        put_desc(32'h140, 32'h180, 32'h500, 32'h700, 32'h8040_0008);
        put_desc(32'h180, 32'h1, 32'h510, 32'h700, 32'h8024_0004);
        expect_wr(32'h700, 32'hA0A1A2A3);
        expect_wr(32'h700, 32'hB0B1B2B3);
        expect_wr(32'h700, 32'h04030201);
        wreg(3'd1, 32'h140);
        wreg(3'd0, 32'h8000_0000);
        wait_stop("R3 chain end");
        rreg(3'd0, v); chk(v == 32'hE, "R4 start and end set", v, 32'hE);
        rreg(3'd1, v); chk(v == 32'h180, "R3 followed next pointer", v, 32'h180);
        chk(sb_q.size() == 0, "R3 all words moved", sb_q.size(), 0);
        wreg(3'd0, 32'h6);

        // R5 R13 source-paced, 8-byte bursts
        put_desc(32'h1C0, 32'h1, 32'h800, 32'h900, 32'h6021_0010);
        for (int k = 0; k < 4; k++) expect_wr(32'h900 + 4*k, 32'hCAFE0001);
        wreg(3'd1, 32'h1C0);
        wreg(3'd0, 32'h8000_0000);
        repeat (40) @(negedge clk);
        chk(sb_q.size() == 4, "R5 no move without dreq", sb_q.size(), 4);
        rreg(3'd0, v); chk(v == 32'h8000_0100, "R5 waiting flag", v, 32'h8000_0100);
        wreg(3'd2, 32'h1234);
        rreg(3'd2, v); chk(v == 32'h800, "R13 write ignored while running", v, 32'h800);
        @(negedge clk); dreq = 1'b1; @(negedge clk); dreq = 1'b0;
        repeat (40) @(negedge clk);
        chk(sb_q.size() == 2, "R5 one burst per request", sb_q.size(), 2);
        @(negedge clk); dreq = 1'b1; @(negedge clk); dreq = 1'b0;
        wait_stop("R5 chain end");
        chk(sb_q.size() == 0, "R5 all words moved", sb_q.size(), 0);
        wreg(3'd0, 32'h4);

        // R11 register-only transfer
        wreg(3'd2, 32'h400);
        wreg(3'd3, 32'hA00);
        wreg(3'd4, 32'hC020_0004);
        expect_wr(32'hA00, 32'h11111111);
        wreg(3'd0, 32'hC000_0000);
        wait_stop("R11 end");
        rreg(3'd0, v); chk(v == 32'h4000_000C, "R11 status", v, 32'h4000_000C);
        rreg(3'd1, v); chk(v == 32'h1C0, "R11 no descriptor fetch", v, 32'h1C0);
        chk(sb_q.size() == 0, "R11 word moved", sb_q.size(), 0);
        wreg(3'd0, 32'h4);

        // R10 bus error on source read
        put_desc(32'h200, 32'h1, 32'h8000_0000, 32'hB00, 32'hC020_0004);
        wreg(3'd1, 32'h200);
        wreg(3'd0, 32'h8000_0000);
        wait_stop("R10 stop on error");
        rreg(3'd0, v); chk(v == 32'h9, "R10 error status", v, 32'h9);
        chk(irq == 1'b1, "R14 irq on error", {31'b0, irq}, 32'h1);
        wreg(3'd0, 32'h1);

        // R14 R9 stop interrupt enable
        wreg(3'd0, 32'h2000_0000);
        rreg(3'd0, v); chk(v == 32'h2000_0008, "R9 enable readback", v, 32'h2000_0008);
        chk(irq == 1'b1, "R14 stop irq", {31'b0, irq}, 32'h1);
        wreg(3'd0, 32'h0);
        chk(irq == 1'b0, "R14 stop irq off", {31'b0, irq}, 32'h0);

        // R12 R8 cyclic chain, then halt
        sb_on = 1'b0;
        put_desc(32'h240, 32'h280, 32'h400, 32'hC00, 32'hC020_0004);
        put_desc(32'h280, 32'h240, 32'h404, 32'hC04, 32'hC000_0004);
        wreg(3'd1, 32'h240);
        wreg(3'd0, 32'h8000_0000);
        do begin @(negedge clk); rreg(3'd0, v); end while (!v[2]);
        wc0 = wr_count;
        wreg(3'd0, 32'h8000_0004);
        do begin @(negedge clk); rreg(3'd0, v); end while (!v[2]);
        chk(wr_count >= wc0 + 2, "R12 chain repeats", wr_count, wc0 + 2);
        rreg(3'd2, v);
        chk(v == 32'h400 || v == 32'h404 || v == 32'h408, "R13 source readable", v, 32'h400);
        wreg(3'd0, 32'h0);
        repeat (20) @(negedge clk);
        rreg(3'd0, v);
        chk((v & 32'h8000_0008) == 32'h8, "R8 halted", v, 32'h8);
        wc0 = wr_count;
        repeat (20) @(negedge clk);
        chk(wr_count == wc0, "R8 no writes after halt", wr_count, wc0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule